// File: doc/BRIEF.md
# Two-Master Bus Arbiter with External Release

This block decides which of two on-chip masters owns the internal bus: a data-transfer controller, which is favoured, and a CPU. Each master has two request lines. One is for accesses that stay inside the chip. The other is for accesses that go out over the external bus. The arbiter answers with one acknowledge per master, and a master keeps the bus for as long as its acknowledge stays high. Ownership is only reconsidered on a cycle-done strobe, so a bus cycle in flight is never cut short.

Alongside the internal grant, a second path handles an off-chip device that asks to take the external bus. That release request wins over any internal external access seen at the same boundary. While the release is held, masters can still make internal accesses. Masters that want the external bus wait without an acknowledge. The release path is shut off when the chip is asleep and the module-stop word holds one of two all-stopped codes.

Top module: `bus_arb_top`

## Requirements
- R1: After reset, the DTC acknowledge, the CPU acknowledge and the release acknowledge are all low.
- R2: Acknowledges and the release acknowledge change only on the clock edge at which cycle_done_i is high.
- R3: When the bus is free at a boundary and both masters are eligible, the DTC is granted.
- R4: At most one master acknowledge is high at a time. In the cycle after any acknowledge drops, no acknowledge is high, so a new grant comes at a later boundary.
- R5: A DTC owner keeps the bus while it stays eligible. A CPU owner gives up the bus at the first boundary where the DTC is eligible. An owner that is no longer eligible (the CPU only if stalled) loses its acknowledge.
- R6: At a boundary with the bus free and no eligible DTC, the CPU is granted as default owner, even with no request. It keeps the bus while nobody else is eligible.
- R7: The release acknowledge rises at a boundary where the release request is high and the release path is enabled. It falls at a boundary where the request is low.
- R8: A master is eligible through its internal request, or through its external request only when no release will be held after the boundary. So a release wins over a simultaneous external access, and an owner that is making only an external access is dropped when a release starts.
- R9: An internal-access request is granted and held while the release acknowledge is high.
- R10: With sleep_i high and mstop_i equal to 16'hFFFF or 16'hEFFF, release requests are not acknowledged. An active release drops at the next boundary. Any other stop code, or sleep low, leaves release enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_done_i | input | 1 | Bus-cycle boundary strobe |
| dtc_int_req_i | input | 1 | DTC request, internal access |
| dtc_ext_req_i | input | 1 | DTC request, external access |
| cpu_int_req_i | input | 1 | CPU request, internal access |
| cpu_ext_req_i | input | 1 | CPU request, external access |
| rel_req_i | input | 1 | Off-chip bus-release request |
| sleep_i | input | 1 | Chip in sleep mode |
| mstop_i | input | 16 | Module-stop register value |
| dtc_ack_o | output | 1 | DTC bus acknowledge |
| cpu_ack_o | output | 1 | CPU bus acknowledge |
| rel_ack_o | output | 1 | External bus released |

## Verification
The bench builds the block with its default parameters: two masters with the DTC at index 0, a 16-bit stop word, and the two all-stopped codes. These values let it reach the full priority ladder, the default-owner hold, the yield from CPU to DTC, and the stall and resume of external accesses across a release. They also cover both disabling stop codes, a non-disabling code, and a release cut off by entering sleep.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int unsigned NMST    = 2;
  localparam int unsigned DTC_IDX = 0;  // index 0 is highest priority
  localparam int unsigned CPU_IDX = 1;  // default owner
  localparam int unsigned STOP_W  = 16;
  localparam logic [STOP_W-1:0] STOP_ALL_A = 16'hFFFF;
  localparam logic [STOP_W-1:0] STOP_ALL_B = 16'hEFFF;
endpackage

// File: rtl/rel_ctrl.sv
module rel_ctrl #(
  parameter int unsigned STOP_W = 16,
  parameter logic [STOP_W-1:0] CODE_A = '1,
  parameter logic [STOP_W-1:0] CODE_B = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cycle_done_i,
  input  logic              rel_req_i,
  input  logic              sleep_i,
  input  logic [STOP_W-1:0] mstop_i,
  output logic              rel_nxt_o,
  output logic              rel_ack_o
);
  logic stop_all, rel_en, rel_q;

  assign stop_all  = (mstop_i == CODE_A) || (mstop_i == CODE_B);
  assign rel_en    = !(sleep_i && stop_all);
  assign rel_nxt_o = cycle_done_i ? (rel_req_i && rel_en) : rel_q;
  assign rel_ack_o = rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rel_q <= 1'b0;
    else         rel_q <= rel_nxt_o;
  end

  // R10
  rel_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rel_q) |-> $past(rel_en && rel_req_i && cycle_done_i));
  // R2
  rel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cycle_done_i) |-> $stable(rel_q));
endmodule

// File: rtl/req_qual.sv
module req_qual #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] int_req_i,
  input  logic [N-1:0] ext_req_i,
  input  logic         rel_nxt_i,
  output logic [N-1:0] elig_o,
  output logic [N-1:0] stall_o
);
  for (genvar k = 0; k < N; k++) begin : g_m
    // external access waits while the bus is released
    assign elig_o[k]  = int_req_i[k] || (ext_req_i[k] && !rel_nxt_i);
    assign stall_o[k] = ext_req_i[k] && !int_req_i[k] && rel_nxt_i;
  end
endmodule

// File: rtl/int_arb.sv
module int_arb #(
  parameter int unsigned N       = 2,
  parameter int unsigned DEF_IDX = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cycle_done_i,
  input  logic [N-1:0] elig_i,
  input  logic [N-1:0] stall_i,
  output logic [N-1:0] ack_o
);
  logic [N-1:0] grant_q, grant_d, hi_mask, pick;
  logic         keep;

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int k = 0; k < N; k++) begin
      hi_mask[k] = acc;
      acc        = acc | elig_i[k];
    end
  end
  assign pick = elig_i & ~hi_mask;

  always_comb begin
    keep = 1'b0;
    for (int k = 0; k < N; k++)
      if (grant_q[k])
        keep = !hi_mask[k] && !stall_i[k] && (elig_i[k] || k == int'(DEF_IDX));
  end

  always_comb begin
    grant_d = grant_q;
    if (cycle_done_i) begin
      if (grant_q == '0) begin
        if (|elig_i)                grant_d = pick;
        else if (!stall_i[DEF_IDX]) grant_d = N'(1) << DEF_IDX;
        else                        grant_d = '0;
      end else begin
        grant_d = keep ? grant_q : '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) grant_q <= '0;
    else         grant_q <= grant_d;
  end
  assign ack_o = grant_q;

  // R4
  ack_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant_q));
  // R2
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cycle_done_i) |-> $stable(grant_q));
  // R4
  ack_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(grant_q) & ~grant_q)) |-> (grant_q == '0));
  // R3
  ack_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(grant_q & ~$past(grant_q))) |-> ((grant_q & $past(hi_mask)) == '0));
endmodule

// File: rtl/bus_arb_top.sv
module bus_arb_top
  import bus_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cycle_done_i,
  input  logic              dtc_int_req_i,
  input  logic              dtc_ext_req_i,
  input  logic              cpu_int_req_i,
  input  logic              cpu_ext_req_i,
  input  logic              rel_req_i,
  input  logic              sleep_i,
  input  logic [STOP_W-1:0] mstop_i,
  output logic              dtc_ack_o,
  output logic              cpu_ack_o,
  output logic              rel_ack_o
);
  logic [NMST-1:0] int_req, ext_req, elig, stall, ack;
  logic            rel_nxt;

  always_comb begin
    int_req = '0;
    ext_req = '0;
    int_req[DTC_IDX] = dtc_int_req_i;
    int_req[CPU_IDX] = cpu_int_req_i;
    ext_req[DTC_IDX] = dtc_ext_req_i;
    ext_req[CPU_IDX] = cpu_ext_req_i;
  end

  rel_ctrl #(.STOP_W(STOP_W), .CODE_A(STOP_ALL_A), .CODE_B(STOP_ALL_B)) u_rel (
    .clk_i, .rst_ni, .cycle_done_i, .rel_req_i, .sleep_i, .mstop_i,
    .rel_nxt_o(rel_nxt), .rel_ack_o(rel_ack_o));

  req_qual #(.N(NMST)) u_qual (
    .int_req_i(int_req), .ext_req_i(ext_req), .rel_nxt_i(rel_nxt),
    .elig_o(elig), .stall_o(stall));

  int_arb #(.N(NMST), .DEF_IDX(CPU_IDX)) u_arb (
    .clk_i, .rst_ni, .cycle_done_i, .elig_i(elig), .stall_i(stall), .ack_o(ack));

  assign dtc_ack_o = ack[DTC_IDX];
  assign cpu_ack_o = ack[CPU_IDX];
endmodule

// File: tb/bus_arb_top_bench.sv
module bus_arb_top_bench;
  logic clk = 1'b0, rst_ni = 1'b0, cycle_done = 1'b0;
  logic dtc_int = 0, dtc_ext = 0, cpu_int = 0, cpu_ext = 0, rel_req = 0, sleep = 0;
  logic [15:0] mstop = '0;
  logic dtc_ack, cpu_ack, rel_ack;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_arb_top u_bus_arb_top (
    .clk_i(clk), .rst_ni(rst_ni), .cycle_done_i(cycle_done),
    .dtc_int_req_i(dtc_int), .dtc_ext_req_i(dtc_ext),
    .cpu_int_req_i(cpu_int), .cpu_ext_req_i(cpu_ext),
    .rel_req_i(rel_req), .sleep_i(sleep), .mstop_i(mstop),
    .dtc_ack_o(dtc_ack), .cpu_ack_o(cpu_ack), .rel_ack_o(rel_ack));

  // exp = {dtc, cpu, rel}
  task automatic chk(input string req, input logic [2:0] exp);
    checks++;
    if ({dtc_ack, cpu_ack, rel_ack} !== exp) begin
      failures++;
      $display("FAIL %s: {dtc,cpu,rel} actual=%b expected=%b", req,
               {dtc_ack, cpu_ack, rel_ack}, exp);
    end
  endtask

  task automatic tick(input logic done);
    cycle_done = done;
    @(posedge clk);
    @(negedge clk);
    cycle_done = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset", 3'b000);
    rst_ni = 1'b1;
    tick(0); chk("R1 idle after reset", 3'b000);
  endtask

  task automatic t_default();
    tick(0); chk("R2 no boundary no grant", 3'b000);
    tick(1); chk("R6 cpu default", 3'b010);
    tick(1); chk("R6 default holds", 3'b010);
  endtask

  task automatic t_priority();
    dtc_int = 1;
    tick(0); chk("R2 hold mid-cycle", 3'b010);
    tick(1); chk("R5 cpu yields / R4 gap", 3'b000);
    tick(1); chk("R3 dtc granted", 3'b100);
    cpu_int = 1;
    tick(1); chk("R5 dtc keeps", 3'b100);
    dtc_int = 0;
    tick(1); chk("R5 dtc released / R4 gap", 3'b000);
    tick(1); chk("R6 cpu granted", 3'b010);
    cpu_int = 0;
    tick(1); chk("R6 cpu keeps idle", 3'b010);
  endtask

  task automatic t_both();
    dtc_int = 1; cpu_int = 1;
    tick(1); chk("R5 cpu yields", 3'b000);
    tick(1); chk("R3 both request dtc wins", 3'b100);
    dtc_int = 0; cpu_int = 0;
    tick(1); chk("R4 gap", 3'b000);
    tick(1); chk("R6 cpu back", 3'b010);
  endtask

  task automatic t_overlap();
    rel_req = 1; dtc_int = 1;
    tick(1); chk("R7 release rises", 3'b001);
    tick(1); chk("R9 internal during release", 3'b101);
    rel_req = 0;
    tick(0); chk("R2 release holds mid-cycle", 3'b101);
    tick(1); chk("R7 release falls", 3'b100);
    dtc_int = 0;
    tick(1); chk("R4 gap", 3'b000);
    tick(1); chk("R6 cpu back", 3'b010);
  endtask

  task automatic t_clash();
    cpu_ext = 1; dtc_ext = 1; rel_req = 1;
    tick(1); chk("R8 release wins, owner dropped", 3'b001);
    tick(1); chk("R8 external stalled", 3'b001);
    rel_req = 0;
    tick(1); chk("R8 stall ends dtc granted", 3'b100);
    dtc_ext = 0;
    tick(1); chk("R4 gap", 3'b000);
    tick(1); chk("R8 cpu external granted", 3'b010);
    cpu_ext = 0;
  endtask

  task automatic t_sleep();
    sleep = 1; mstop = 16'hFFFF; rel_req = 1;
    tick(1); chk("R10 FFFF blocks", 3'b010);
    mstop = 16'hEFFF;
    tick(1); chk("R10 EFFF blocks", 3'b010);
    mstop = 16'h7FFF;
    tick(1); chk("R10 other code allows", 3'b011);
    rel_req = 0;
    tick(1); chk("R7 release ends", 3'b010);
    sleep = 0; mstop = 16'hFFFF; rel_req = 1;
    tick(1); chk("R10 awake allows", 3'b011);
    sleep = 1;
    tick(1); chk("R10 sleep drops release", 3'b010);
    sleep = 0; rel_req = 0; mstop = '0;
  endtask

  initial begin
    t_reset();
    t_default();
    t_priority();
    t_both();
    t_overlap();
    t_clash();
    t_sleep();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule